// File: doc/BRIEF.md
# Multi-Match PWM Timer

This block is a free-running up-counter with seven compare values. Compare value 0 sets the period. The other six compare values drive six pulse-width outputs. Software chooses, output by output, between two modes. In the first, the output rises at the start of the period and falls at its own compare point. In the second, the output rises at the previous channel's compare point and falls at its own. Because the seven compare values are shared, any mix of the two modes can run at once.

With pulse-width mode off, the same counter and compare values act as a plain match timer. In that mode the outputs stay low and compare writes land at once. Two capture channels copy the counter when their input shows a selected edge. Compare hits and captures set sticky flags, which can be routed to one interrupt line.

In pulse-width mode, compare writes only fill a staging copy. A staged value moves into the live compare register at the next period restart, and only if software has armed it. This lets software change several duty cycles together without glitches.

Top module: `pwm_timer`

## Requirements
- R1: While run (CTRL bit 0) is set, the counter steps by one each clock. In the clock after it equals compare 0 it reads 0, so the period is compare0+1 clocks. With run clear the counter holds. While clear-hold (CTRL bit 2) is set the counter reads 0 and no compare hits occur. The counter is read at address 6.
- R2: An output whose mode bit (OUTMODE bit n-1) is 0 is a single-edge output n. It is high for counter values 0 through compare n, giving compare n + 1 high clocks per period when compare n <= compare 0. When compare n equals compare 0 it stays high.
- R3: An output whose mode bit is 1 is a double-edge output n. It rises after compare n-1 hits and falls after compare n hits, giving compare n - compare (n-1) high clocks when compare (n-1) < compare n <= compare 0.
- R4: Output n is driven only when its enable bit (OUTMODE bit 8+n-1) is set and pulse-width mode (CTRL bit 1) is set. Otherwise it is low.
- R5: In pulse-width mode, a write to compare address 8+i changes only the staged copy, and reads of 8+i return the live value. At the next period restart, each compare whose arm bit is set (ARM register, address 5, bit i) takes its staged value, and all arm bits then read 0.
- R6: With pulse-width mode off, a write to compare address 8+i takes effect at once and reads back in the next clock.
- R7: A hit on compare i sets FLAGS (address 4) bit i, and a capture on channel c sets bit 7+c. Writing 1 to a FLAGS bit clears it, and writing 0 leaves it unchanged.
- R8: irq is high exactly when some FLAGS bit is set and its enable bit in IRQEN (address 2, same bit positions) is also set.
- R9: Capture channel c copies the counter into its register (address 16+c) on a rising input edge when CAPCFG (address 3) bit 2c is set, and on a falling edge when bit 2c+1 is set. An edge that is not selected changes neither the register nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 5 | Register address for write and read |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr (combinational) |
| capIn | input | 2 | Capture inputs |
| pwmOut | output | 6 | Pulse-width outputs, bit n-1 is output n |
| irq | output | 1 | Interrupt |

## Verification
The compare set 9,3,7,5,8,0,9 runs all six outputs together in a mix of both modes. That single pattern separates the single-edge and double-edge counts, and it also covers a compare at 0 (one-clock pulse) and a compare equal to the period (always high). A second pattern rewrites compare 1 through the staging copy. It shows no effect before arming and after arming without a restart, then shows a shifted duty on both outputs that use compare 1. The timer-mode pattern uses a short period with a compare beyond it, so the flags show exactly which compares hit. Captures driven with rising-only and falling-only selection tell the selected edge apart from the ignored one.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int NUM_MATCH = 7;
  localparam int NUM_OUT   = NUM_MATCH - 1;
  localparam int NUM_CAP   = 2;
  localparam int NUM_FLAG  = NUM_MATCH + NUM_CAP;
  localparam int ADDR_W    = 5;
  localparam int EN_LSB    = 8;

  localparam logic [ADDR_W-1:0] A_CTRL   = 5'd0;
  localparam logic [ADDR_W-1:0] A_OUTM   = 5'd1;
  localparam logic [ADDR_W-1:0] A_IEN    = 5'd2;
  localparam logic [ADDR_W-1:0] A_CAPCFG = 5'd3;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 5'd4;
  localparam logic [ADDR_W-1:0] A_ARM    = 5'd5;
  localparam logic [ADDR_W-1:0] A_COUNT  = 5'd6;
  localparam logic [ADDR_W-1:0] A_MATCH0 = 5'd8;
  localparam logic [ADDR_W-1:0] A_CAP0   = 5'd16;

  typedef struct packed {
    logic                 run;
    logic                 pwmMode;
    logic                 cntClr;
    logic [NUM_MATCH-1:0] directWr;
    logic [NUM_MATCH-1:0] latchArm;
  } pwmStrobeT;
endpackage

// File: rtl/pwm_timer_ctrl.sv
module pwm_timer_ctrl
  import pwm_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 wrEn,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic [DATA_W-1:0]                    wrData,
  output logic [DATA_W-1:0]                    rdData,
  input  logic [NUM_MATCH-1:0]                 matchHit,
  input  logic [NUM_CAP-1:0]                   capHit,
  input  logic                                 boundary,
  input  logic [DATA_W-1:0]                    cnt,
  input  logic [NUM_MATCH-1:0][DATA_W-1:0]     activeMatch,
  input  logic [NUM_CAP-1:0][DATA_W-1:0]       capVal,
  output pwmStrobeT                            strb,
  output logic [NUM_MATCH-1:0][DATA_W-1:0]     shadow,
  output logic [NUM_OUT-1:0]                   dblSel,
  output logic [NUM_OUT-1:0]                   outEn,
  output logic [NUM_CAP-1:0]                   capRise,
  output logic [NUM_CAP-1:0]                   capFall,
  output logic                                 irq
);
  logic [2:0]           ctrlQ;
  logic [NUM_OUT-1:0]   dblQ, enQ;
  logic [NUM_FLAG-1:0]  ienQ, flagsQ, flagClr;
  logic [2*NUM_CAP-1:0] capCfgQ;
  logic [NUM_MATCH-1:0] armQ, armSet, armClr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      dblQ    <= '0;
      enQ     <= '0;
      ienQ    <= '0;
      capCfgQ <= '0;
    end else if (wrEn) begin
      case (addr)
        A_CTRL:   ctrlQ   <= wrData[2:0];
        A_OUTM: begin
          dblQ <= wrData[NUM_OUT-1:0];
          enQ  <= wrData[EN_LSB +: NUM_OUT];
        end
        A_IEN:    ienQ    <= wrData[NUM_FLAG-1:0];
        A_CAPCFG: capCfgQ <= wrData[2*NUM_CAP-1:0];
        default: ;
      endcase
    end
  end

  genvar i;
  generate
    for (i = 0; i < NUM_MATCH; i++) begin : gShadow
      always_ff @(posedge clk) begin
        if (!rstN) shadow[i] <= '0;
        else if (wrEn && addr == A_MATCH0 + ADDR_W'(i)) shadow[i] <= wrData;
      end
      assign strb.directWr[i] = wrEn && (addr == A_MATCH0 + ADDR_W'(i)) && !ctrlQ[1];
    end
    for (i = 0; i < NUM_CAP; i++) begin : gCapCfg
      assign capRise[i] = capCfgQ[2*i];
      assign capFall[i] = capCfgQ[2*i+1];
    end
  endgenerate

  assign flagClr = (wrEn && addr == A_FLAGS) ? wrData[NUM_FLAG-1:0] : '0;
  assign armSet  = (wrEn && addr == A_ARM) ? wrData[NUM_MATCH-1:0] : '0;
  assign armClr  = (boundary && ctrlQ[1]) ? armQ : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsQ <= '0;
      armQ   <= '0;
    end else begin
      flagsQ <= (flagsQ & ~flagClr) | {capHit, matchHit};
      armQ   <= (armQ & ~armClr) | armSet;
    end
  end

  assign strb.run      = ctrlQ[0];
  assign strb.pwmMode  = ctrlQ[1];
  assign strb.cntClr   = ctrlQ[2];
  assign strb.latchArm = armQ;
  assign dblSel        = dblQ;
  assign outEn         = enQ;
  assign irq           = |(flagsQ & ienQ);

  always_comb begin
    rdData = '0;
    case (addr)
      A_CTRL:   rdData = DATA_W'(ctrlQ);
      A_OUTM: begin
        rdData[NUM_OUT-1:0]        = dblQ;
        rdData[EN_LSB +: NUM_OUT]  = enQ;
      end
      A_IEN:    rdData = DATA_W'(ienQ);
      A_CAPCFG: rdData = DATA_W'(capCfgQ);
      A_FLAGS:  rdData = DATA_W'(flagsQ);
      A_ARM:    rdData = DATA_W'(armQ);
      A_COUNT:  rdData = cnt;
      default: ;
    endcase
    for (int k = 0; k < NUM_MATCH; k++)
      if (addr == A_MATCH0 + ADDR_W'(k)) rdData = activeMatch[k];
    for (int k = 0; k < NUM_CAP; k++)
      if (addr == A_CAP0 + ADDR_W'(k)) rdData = capVal[k];
  end

  // R7: every compare hit is recorded in the flag register
  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|matchHit) |=> ((flagsQ[NUM_MATCH-1:0] & $past(matchHit)) == $past(matchHit)));

  // R5: arm bits drop at a pulse-width period restart
  assert_arm_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (boundary && ctrlQ[1] && !(wrEn && addr == A_ARM)) |=> (armQ == '0));
endmodule

// File: rtl/pwm_timer_dp.sv
module pwm_timer_dp
  import pwm_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  pwmStrobeT                            strb,
  input  logic [DATA_W-1:0]                    wrData,
  input  logic [NUM_MATCH-1:0][DATA_W-1:0]     shadow,
  input  logic [NUM_OUT-1:0]                   dblSel,
  input  logic [NUM_OUT-1:0]                   outEn,
  input  logic [NUM_CAP-1:0]                   capRise,
  input  logic [NUM_CAP-1:0]                   capFall,
  input  logic [NUM_CAP-1:0]                   capIn,
  output logic [NUM_MATCH-1:0]                 matchHit,
  output logic [NUM_CAP-1:0]                   capHit,
  output logic                                 boundary,
  output logic [DATA_W-1:0]                    cnt,
  output logic [NUM_MATCH-1:0][DATA_W-1:0]     activeMatch,
  output logic [NUM_CAP-1:0][DATA_W-1:0]       capVal,
  output logic [NUM_OUT-1:0]                   pwmOut
);
  logic [DATA_W-1:0]  cntQ;
  logic [NUM_OUT-1:0] pwmQ;
  logic [NUM_CAP-1:0] capPrevQ;
  logic               counting;

  assign counting = strb.run && !strb.cntClr;
  assign boundary = matchHit[0];
  assign cnt      = cntQ;

  always_ff @(posedge clk) begin
    if (!rstN || strb.cntClr) cntQ <= '0;
    else if (strb.run)        cntQ <= boundary ? '0 : cntQ + DATA_W'(1);
  end

  genvar i;
  generate
    for (i = 0; i < NUM_MATCH; i++) begin : gMatch
      assign matchHit[i] = counting && (cntQ == activeMatch[i]);
      always_ff @(posedge clk) begin
        if (!rstN)                                                activeMatch[i] <= '0;
        else if (strb.directWr[i])                                activeMatch[i] <= wrData;
        else if (strb.pwmMode && boundary && strb.latchArm[i])    activeMatch[i] <= shadow[i];
      end
    end

    for (i = 0; i < NUM_OUT; i++) begin : gOut
      logic setEv, clrEv;
      assign setEv = dblSel[i] ? matchHit[i] : boundary;
      assign clrEv = matchHit[i+1];
      always_ff @(posedge clk) begin
        if (!rstN || !strb.pwmMode) pwmQ[i] <= 1'b0;
        else if (dblSel[i])          pwmQ[i] <= clrEv ? 1'b0 : (setEv ? 1'b1 : pwmQ[i]);
        else                         pwmQ[i] <= setEv ? 1'b1 : (clrEv ? 1'b0 : pwmQ[i]);
      end
      // R2: a single-edge output is high in the first clock of every period
      assert_single_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
        (strb.pwmMode && boundary && !dblSel[i]) |=> pwmQ[i]);
    end

    for (i = 0; i < NUM_CAP; i++) begin : gCap
      assign capHit[i] = (capRise[i] && capIn[i] && !capPrevQ[i]) ||
                         (capFall[i] && !capIn[i] && capPrevQ[i]);
      always_ff @(posedge clk) begin
        if (!rstN) begin
          capPrevQ[i] <= 1'b0;
          capVal[i]   <= '0;
        end else begin
          capPrevQ[i] <= capIn[i];
          if (capHit[i]) capVal[i] <= cntQ;
        end
      end
      // R9: the capture register holds the count seen at the edge
      assert_capture_R9: assert property (@(posedge clk) disable iff (!rstN)
        capHit[i] |=> (capVal[i] == $past(cntQ)));
    end
  endgenerate

  assign pwmOut = pwmQ & outEn & {NUM_OUT{strb.pwmMode}};

  // R1: counter restarts after reaching the period value
  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rstN)
    boundary |=> (cntQ == '0));

  // R1: counter steps by one inside the period
  assert_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (counting && !boundary) |=> (cntQ == $past(cntQ) + DATA_W'(1)));

  // R5: live compare values stay put in pulse-width mode between restarts
  assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pwmMode && !boundary) |=> $stable(activeMatch));
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_CAP-1:0] capIn,
  output logic [NUM_OUT-1:0] pwmOut,
  output logic               irq
);
  pwmStrobeT                        strb;
  logic [NUM_MATCH-1:0][DATA_W-1:0] shadow, activeMatch;
  logic [NUM_CAP-1:0][DATA_W-1:0]   capVal;
  logic [NUM_MATCH-1:0]             matchHit;
  logic [NUM_CAP-1:0]               capHit, capRise, capFall;
  logic [NUM_OUT-1:0]               dblSel, outEn;
  logic                             boundary;
  logic [DATA_W-1:0]                cnt;

  pwm_timer_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .matchHit(matchHit), .capHit(capHit), .boundary(boundary),
    .cnt(cnt), .activeMatch(activeMatch), .capVal(capVal), .strb(strb),
    .shadow(shadow), .dblSel(dblSel), .outEn(outEn), .capRise(capRise),
    .capFall(capFall), .irq(irq)
  );

  pwm_timer_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .shadow(shadow),
    .dblSel(dblSel), .outEn(outEn), .capRise(capRise), .capFall(capFall),
    .capIn(capIn), .matchHit(matchHit), .capHit(capHit), .boundary(boundary),
    .cnt(cnt), .activeMatch(activeMatch), .capVal(capVal), .pwmOut(pwmOut)
  );
endmodule

// File: tb/pwm_timer_bench.sv
`timescale 1ns/1ps
module pwm_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [1:0]  capIn = '0;
  logic [5:0]  pwmOut;
  logic        irq;

  always #2.5 clk = ~clk;

  pwm_timer u_pwm_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .capIn(capIn), .pwmOut(pwmOut), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string       expTag[$];
  logic [31:0] expVal[$];
  logic [31:0] actVal[$];

  // scoreboard monitor: pops expected items as results arrive
  initial begin
    forever begin
      wait (actVal.size() != 0);
      begin
        string       t;
        logic [31:0] e, a;
        t = expTag.pop_front();
        e = expVal.pop_front();
        a = actVal.pop_front();
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s actual=%0h expected=%0h", t, a, e);
        end
      end
    end
  end

  task automatic expectItem(input string tag, input logic [31:0] exp);
    expTag.push_back(tag);
    expVal.push_back(exp);
  endtask

  task automatic result(input logic [31:0] act);
    actVal.push_back(act);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdVal(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdData;
  endtask

  task automatic rdChk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    expectItem(tag, exp);
    rdVal(a, v);
    result(v);
  endtask

  task automatic highCount(input string tag, input int ch, input int exp);
    int c = 0;
    expectItem(tag, 32'(exp));
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      c += int'(pwmOut[ch]);
    end
    result(32'(c));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] c0, c1;
    idle(4);
    rstN = 1'b1;
    // reset state
    rdChk("R1 reset count", 5'd6, 0);
    rdChk("R7 reset flags", 5'd4, 0);
    expectItem("R4 reset outputs", 0); result(32'(pwmOut));
    expectItem("R8 reset irq", 0);     result(32'(irq));

    // compares written in timer mode land at once
    wr(5'd8, 9); wr(5'd9, 3); wr(5'd10, 7); wr(5'd11, 5);
    wr(5'd12, 8); wr(5'd13, 0); wr(5'd14, 9);
    rdChk("R6 direct write", 5'd9, 3);
    wr(5'd1, 32'h3F0A);       // outputs 2 and 4 double-edge, all enabled
    wr(5'd0, 3);              // run + pulse-width mode
    idle(25);
    highCount("R2 out1 single", 0, 4);
    highCount("R3 out2 double", 1, 4);
    highCount("R2 out3 single", 2, 6);
    highCount("R3 out4 double", 3, 3);
    highCount("R2 out5 compare zero", 4, 1);
    highCount("R2 out6 compare equals period", 5, 10);

    // R4: disable output 3
    wr(5'd1, 32'h3B0A);
    idle(2);
    highCount("R4 out3 disabled", 2, 0);
    wr(5'd1, 32'h3F0A);

    // R5: staged write without arming
    wr(5'd9, 6);
    idle(20);
    rdChk("R5 live unchanged", 5'd9, 3);
    highCount("R5 out1 unchanged", 0, 4);
    wr(5'd0, 2);              // stop, keep pulse-width mode
    wr(5'd5, 2);
    rdChk("R5 arm pending", 5'd5, 2);
    rdChk("R5 live before restart", 5'd9, 3);
    wr(5'd0, 3);
    idle(20);
    rdChk("R5 arm cleared", 5'd5, 0);
    rdChk("R5 live committed", 5'd9, 6);
    highCount("R5 out1 new duty", 0, 7);
    highCount("R5 out2 new duty", 1, 1);

    // timer mode: hits, flags, irq
    wr(5'd0, 4);              // hold counter at zero, timer mode
    rdChk("R1 clear hold", 5'd6, 0);
    expectItem("R4 timer mode outputs", 0); result(32'(pwmOut));
    wr(5'd8, 4);
    rdChk("R6 period immediate", 5'd8, 4);
    wr(5'd10, 2);
    rdChk("R6 compare2 immediate", 5'd10, 2);
    wr(5'd2, 32'h004);
    wr(5'd4, 32'h1FF);
    rdChk("R7 flags cleared", 5'd4, 0);
    wr(5'd0, 1);
    idle(12);
    wr(5'd0, 0);
    rdChk("R7 hit flags", 5'd4, 32'h25);
    expectItem("R8 irq on enabled flag", 1); result(32'(irq));
    wr(5'd4, 32'h004);
    rdChk("R7 partial clear", 5'd4, 32'h21);
    expectItem("R8 irq off", 0); result(32'(irq));
    rdVal(5'd6, c0);
    idle(5);
    expectItem("R1 stopped counter holds", c0);
    rdVal(5'd6, c1); result(c1);

    // R9: capture
    wr(5'd8, 1000);
    wr(5'd0, 4);
    wr(5'd0, 1);
    idle(7);
    wr(5'd0, 0);
    rdVal(5'd6, c0);
    wr(5'd3, 32'h9);          // ch0 rising, ch1 falling
    wr(5'd2, 32'h180);
    wr(5'd4, 32'h1FF);
    @(negedge clk); capIn[0] = 1'b1;
    idle(2);
    rdChk("R9 ch0 rising capture", 5'd16, c0);
    rdChk("R7 ch0 capture flag", 5'd4, 32'h080);
    expectItem("R8 irq on capture", 1); result(32'(irq));
    @(negedge clk); capIn[1] = 1'b1;
    idle(2);
    rdChk("R9 ch1 rising ignored", 5'd17, 0);
    rdChk("R9 ch1 no flag", 5'd4, 32'h080);
    @(negedge clk); capIn[1] = 1'b0;
    idle(2);
    rdChk("R9 ch1 falling capture", 5'd17, c0);
    rdChk("R7 ch1 capture flag", 5'd4, 32'h180);

    wait (actVal.size() == 0);
    #1;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule